// File: doc/BRIEF.md
# Dual-Slope PWM Timer with Clock Divider

This block is an up/down timer that generates a centre-aligned pulse-width-modulated signal. A free-running divider turns the system clock into a step enable, selectable among divide-by 1, 8, 64, 256 and 1024. On each enabled cycle the count moves one step. It climbs from zero to the all-ones top value, then descends to zero again, so a full waveform period lasts twice the top value in steps (510 steps at the default 8-bit width).

The output level flips where the count meets a compare threshold: low on the rising leg and high on the falling leg. The result is a pulse that sits symmetrically around the zero point of the count. The compare threshold is sampled into a holding register every cycle. It becomes active only when the count reaches its top value, so a new threshold never splits a period.

At the top the output is forced to the rising-leg match level even when no match took place. This keeps the pulse symmetric after a threshold change or a missed crossing. A threshold of zero gives a steady low output and a threshold of all ones gives a steady high output. A polarity input inverts every level. A sticky flag marks each return of the count to zero until a clear strobe removes it.

Top module: `pwm_phase_timer`

## Requirements
- R1: `div_sel` codes 0, 1, 2, 3 and 4 select a step every 1, 8, 64, 256 and 1024 clock cycles. Codes 5 to 7 act as code 4. The first step after reset is taken at the clock edge that ends the N-th cycle after reset release.
- R2: The count runs 0, 1, …, TOP, TOP−1, …, 1, 0, 1, … with TOP = 2^CNT_W−1. Its first return to zero after reset comes 2·TOP steps after release.
- R3: For a threshold C with 0 < C < TOP, with `invert` low, `pwm_out` is high for exactly 2·C steps of every 2·TOP-step period. The level falls when the count reaches C rising and rises when the count reaches C falling.
- R4: With `invert` low, an active threshold of 0 holds `pwm_out` low for the whole period, and a threshold of TOP holds it high for the whole period.
- R5: When `invert` is high, `pwm_out` is the complement of the level R3, R4 and R7 define, including the extreme thresholds and the reset state. `invert` takes effect without delay.
- R6: `cmp_in` is copied to a holding register every cycle. The active threshold is loaded from that register only at the step where the count becomes TOP. A threshold change during a rising leg has no effect until the top is reached.
- R7: At the step where the count becomes TOP, the non-inverted level is driven low, the rising-leg match level, whenever the newly active threshold lies strictly between 0 and TOP. This happens even if no match occurred, for example when the threshold has just moved away from TOP.
- R8: `ovf_flag` is set at the step where the count returns to 0 and stays set until `ovf_clr` is high at a clock edge. If a set and a clear fall on the same edge, the set wins.
- R9: A high `rst` at a clock edge clears the count, divider, holding and active thresholds, the direction (to rising), the level and the flag. During reset `pwm_out` equals `invert`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| div_sel | input | 3 | Step divider code (0:/1, 1:/8, 2:/64, 3:/256, 4 to 7:/1024) |
| cmp_in | input | CNT_W | Compare threshold, taken into the holding register each cycle |
| invert | input | 1 | High selects the inverted output polarity |
| pwm_out | output | 1 | PWM waveform |
| ovf_flag | output | 1 | Sticky flag set when the count returns to zero |
| ovf_clr | input | 1 | Clears `ovf_flag` at the next clock edge |

## Verification
The bench builds the block with CNT_W = 5, so TOP is 31 and a period lasts 62 steps, while the divider keeps its full 10-bit width. At that size the divide-by-1024 code completes a whole count cycle within the run, so the timing of every divider code that is tested can be measured through the first flag event after reset. The duty cycle is measured over a full period at several thresholds, including both extremes, in both polarities and at three divider settings. The short period also makes it practical to follow, sample by sample, a threshold that moves away from TOP during a rising leg.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    // Width of the free-running divider; must cover the largest division (1024).
    localparam int unsigned DIV_W_MIN = 10;

    // Divider selection codes.
    typedef enum logic [2:0] {
        DIV_1    = 3'd0,
        DIV_8    = 3'd1,
        DIV_64   = 3'd2,
        DIV_256  = 3'd3,
        DIV_1024 = 3'd4
    } div_sel_e;

    // Count direction for the next step.
    typedef enum logic {
        DIR_RISE = 1'b0,
        DIR_FALL = 1'b1
    } dir_e;

    // Events produced by the counter for the edge that ends this cycle.
    typedef struct packed {
        logic step;      // the count moves at this edge
        logic at_top;    // the count becomes TOP at this edge
        logic at_bottom; // the count becomes zero at this edge
        logic rising;    // the step moves the count upward
    } step_ev_t;

    // Number of low divider bits that must be all ones to release a step.
    function automatic int unsigned div_shift(input logic [2:0] sel);
        case (sel)
            DIV_1:   return 0;
            DIV_8:   return 3;
            DIV_64:  return 6;
            DIV_256: return 8;
            default: return 10;
        endcase
    endfunction

    // Next non-inverted level for one step.
    //   eff     : threshold in force for this step
    //   nxt     : count value after the step
    //   hold_lv : current level
    function automatic logic next_level(
        input logic        at_top,
        input logic        rising,
        input logic        eff_is_top,
        input logic        eff_is_bottom,
        input logic        hit,
        input logic        hold_lv
    );
        if (eff_is_top)         return 1'b1;   // steady high
        else if (eff_is_bottom) return 1'b0;   // steady low
        else if (at_top)        return 1'b0;   // forced rising-leg level
        else if (hit)           return rising ? 1'b0 : 1'b1;
        else                    return hold_lv;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_pkg::*;
#(
    parameter int unsigned DIV_W = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] div_sel,
    output logic       tick
);
    logic [DIV_W-1:0] div_q;
    logic [31:0]      mask_full;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask_full = (32'd1 << div_shift(div_sel)) - 32'd1;
        mask      = mask_full[DIV_W-1:0];
        tick      = ((div_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    // R1: undivided code releases a step every cycle.
    p_every_cycle_r1: assert property (@(posedge clk) disable iff (rst)
        (div_sel == DIV_1) |-> tick);

    // R1: with divide-by-8 held, two steps are never adjacent.
    p_no_adjacent_r1: assert property (@(posedge clk) disable iff (rst)
        (div_sel == DIV_8 && $past(div_sel) == DIV_8 && $past(tick)) |-> !tick);

endmodule

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter
    import pwm_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_nxt,
    output step_ev_t         ev
);
    localparam logic [CNT_W-1:0] TOP    = '1;
    localparam logic [CNT_W-1:0] BOTTOM = '0;

    logic [CNT_W-1:0] cnt_q;
    dir_e             dir_q, dir_n;

    always_comb begin
        cnt_nxt = cnt_q;
        dir_n   = dir_q;
        if (dir_q == DIR_RISE) begin
            if (cnt_q == TOP) begin
                cnt_nxt = TOP - 1'b1;
                dir_n   = DIR_FALL;
            end else begin
                cnt_nxt = cnt_q + 1'b1;
            end
        end else begin
            if (cnt_q == BOTTOM) begin
                cnt_nxt = BOTTOM + 1'b1;
                dir_n   = DIR_RISE;
            end else begin
                cnt_nxt = cnt_q - 1'b1;
            end
        end
        ev.step      = tick;
        ev.at_top    = tick && (cnt_nxt == TOP);
        ev.at_bottom = tick && (cnt_nxt == BOTTOM);
        ev.rising    = (cnt_nxt > cnt_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= BOTTOM;
            dir_q <= DIR_RISE;
        end else if (tick) begin
            cnt_q <= cnt_nxt;
            dir_q <= dir_n;
        end
    end

    // R1: without a step the count holds.
    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q));

    // R2: each step moves the count by exactly one.
    p_unit_step_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1));

    // R2: the count turns around at the top.
    p_turn_top_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_q == TOP) |=> (cnt_q == TOP - 1'b1));

    // R2: the count turns around at zero.
    p_turn_bottom_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_q == BOTTOM) |=> (cnt_q == BOTTOM + 1'b1));

endmodule

// File: rtl/pwm_waveform.sv
module pwm_waveform
    import pwm_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  step_ev_t         ev,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] cmp_in,
    input  logic             invert,
    output logic             pwm_out
);
    localparam logic [CNT_W-1:0] TOP    = '1;
    localparam logic [CNT_W-1:0] BOTTOM = '0;

    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] act_q;
    logic [CNT_W-1:0] eff;
    logic             lvl_q, lvl_n;

    always_comb begin
        eff   = ev.at_top ? hold_q : act_q;
        lvl_n = lvl_q;
        if (ev.step) begin
            lvl_n = next_level(ev.at_top, ev.rising,
                               eff == TOP, eff == BOTTOM,
                               cnt_nxt == eff, lvl_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            act_q  <= '0;
            lvl_q  <= 1'b0;
        end else begin
            hold_q <= cmp_in;
            if (ev.at_top) act_q <= hold_q;
            lvl_q <= lvl_n;
        end
    end

    assign pwm_out = lvl_q ^ invert;

    // R4: threshold zero gives a low level.
    p_floor_low_r4: assert property (@(posedge clk) disable iff (rst)
        (ev.step && eff == BOTTOM) |=> !lvl_q);

    // R4: threshold TOP gives a high level.
    p_ceiling_high_r4: assert property (@(posedge clk) disable iff (rst)
        (ev.step && eff == TOP) |=> lvl_q);

    // R7: reaching the top forces the rising-leg level for inner thresholds.
    p_top_force_r7: assert property (@(posedge clk) disable iff (rst)
        (ev.at_top && hold_q != TOP && hold_q != BOTTOM) |=> !lvl_q);

    // R6: the active threshold changes only at the top.
    p_load_at_top_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_q) |-> $past(ev.at_top));

    // R3: at zero an inner threshold has already raised the level.
    p_high_at_bottom_r3: assert property (@(posedge clk) disable iff (rst)
        (ev.at_bottom && act_q != TOP && act_q != BOTTOM) |=> lvl_q);

endmodule

// File: rtl/pwm_ovf_flag.sv
module pwm_ovf_flag (
    input  logic clk,
    input  logic rst,
    input  logic at_bottom,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)            flag <= 1'b0;
        else if (at_bottom) flag <= 1'b1;
        else if (clr)       flag <= 1'b0;
    end

    // R8: reaching zero always leaves the flag set, clear or not.
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        at_bottom |=> flag);

    // R8: the flag stays set without a clear.
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

endmodule

// File: rtl/pwm_phase_timer.sv
module pwm_phase_timer
    import pwm_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned DIV_W = DIV_W_MIN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       div_sel,
    input  logic [CNT_W-1:0] cmp_in,
    input  logic             invert,
    output logic             pwm_out,
    output logic             ovf_flag,
    input  logic             ovf_clr
);
    logic             tick;
    logic [CNT_W-1:0] cnt_nxt;
    step_ev_t         ev;

    pwm_prescaler #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .div_sel (div_sel),
        .tick    (tick)
    );

    pwm_updown_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .cnt_nxt (cnt_nxt),
        .ev      (ev)
    );

    pwm_waveform #(.CNT_W(CNT_W)) u_wave (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .cnt_nxt (cnt_nxt),
        .cmp_in  (cmp_in),
        .invert  (invert),
        .pwm_out (pwm_out)
    );

    pwm_ovf_flag u_flag (
        .clk       (clk),
        .rst       (rst),
        .at_bottom (ev.at_bottom),
        .clr       (ovf_clr),
        .flag      (ovf_flag)
    );

    // R9: during reset the output shows the polarity input alone.
    p_reset_level_r9: assert property (@(posedge clk)
        $past(rst) |-> (pwm_out == invert) || !rst);

endmodule

// File: tb/tb_pwm_phase_timer.sv
module tb_pwm_phase_timer;
    localparam int unsigned W   = 5;
    localparam int unsigned TOP = (1 << W) - 1;   // 31
    localparam int unsigned PER = 2 * TOP;        // 62 steps

    typedef struct packed {
        logic [2:0]  sel;
        logic        inv;
        logic [4:0]  cmp;
        logic [31:0] exp_hi;
    } vec_t;

    // Expected high cycles over one period = div * (inv ? PER - 2C : 2C)
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 5'd10, 32'd20},    // R3 inner threshold
        '{3'd0, 1'b1, 5'd10, 32'd42},    // R5 inverted inner
        '{3'd0, 1'b0, 5'd0,  32'd0},     // R4 steady low
        '{3'd0, 1'b0, 5'd31, 32'd62},    // R4 steady high
        '{3'd0, 1'b1, 5'd0,  32'd62},    // R5 inverted floor
        '{3'd0, 1'b1, 5'd31, 32'd0},     // R5 inverted ceiling
        '{3'd0, 1'b0, 5'd1,  32'd2},     // R3 smallest inner
        '{3'd0, 1'b0, 5'd30, 32'd60},    // R3 largest inner
        '{3'd1, 1'b0, 5'd5,  32'd80},    // R1 divide by 8
        '{3'd2, 1'b1, 5'd7,  32'd3072}   // R1 divide by 64, inverted
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   div_sel = 3'd0;
    logic [W-1:0] cmp_in = '0;
    logic         invert = 1'b0;
    logic         ovf_clr = 1'b0;
    logic         pwm_out;
    logic         ovf_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pwm_phase_timer #(.CNT_W(W)) dut (
        .clk     (clk),
        .rst     (rst),
        .div_sel (div_sel),
        .cmp_in  (cmp_in),
        .invert  (invert),
        .pwm_out (pwm_out),
        .ovf_flag(ovf_flag),
        .ovf_clr (ovf_clr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] sel, input logic clr_hold);
        @(negedge clk);
        rst = 1'b1; div_sel = sel; cmp_in = '0; invert = 1'b0; ovf_clr = clr_hold;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse_clr();
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
    endtask

    task automatic wait_flag();
        while (!ovf_flag) @(negedge clk);
    endtask

    // Counts edges after release and checks the flag just before and at N*PER.
    task automatic first_bottom(input string tag, input int div);
        for (int i = 1; i <= div * PER; i++) begin
            @(negedge clk);
            if (i == div * PER - 1) chk(tag, int'(ovf_flag), 0);
        end
        chk(tag, int'(ovf_flag), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 reset pwm_out", int'(pwm_out), 0);
        chk("R9 reset ovf_flag", int'(ovf_flag), 0);
        invert = 1'b1;
        @(negedge clk);
        chk("R5 R9 reset inverted pwm_out", int'(pwm_out), 1);
        invert = 1'b0;

        // R2: first return to zero at 2*TOP steps with divide-by-1
        rst = 1'b0;
        first_bottom("R2 first bottom", 1);

        // R8: flag sticky, then cleared
        repeat (20) @(negedge clk);
        chk("R8 flag sticky", int'(ovf_flag), 1);
        pulse_clr();
        chk("R8 flag cleared", int'(ovf_flag), 0);

        // R8: set wins over a clear on the same edge
        do_reset(3'd0, 1'b1);
        first_bottom("R8 set beats clear", 1);
        @(negedge clk);
        chk("R8 clear after set", int'(ovf_flag), 0);
        ovf_clr = 1'b0;

        // R1: divider timing for /8 and /1024
        do_reset(3'd1, 1'b0);
        first_bottom("R1 divide by 8", 8);
        do_reset(3'd4, 1'b0);
        first_bottom("R1 divide by 1024", 1024);

        // Vector table: duty over one full period
        do_reset(3'd0, 1'b0);
        for (int v = 0; v < NV; v++) begin
            int div, hi;
            string tag;
            div_sel = VECS[v].sel;
            invert  = VECS[v].inv;
            cmp_in  = VECS[v].cmp;
            div = 1 << pwm_pkg::div_shift(VECS[v].sel);
            @(negedge clk);
            pulse_clr(); wait_flag();
            pulse_clr(); wait_flag();
            hi = 0;
            for (int k = 0; k < div * PER; k++) begin
                @(negedge clk);
                hi += int'(pwm_out);
            end
            if (VECS[v].sel != 3'd0)                         tag = "R1 duty";
            else if (VECS[v].inv)                            tag = "R5 duty";
            else if (VECS[v].cmp == 0 || VECS[v].cmp == TOP) tag = "R4 duty";
            else                                             tag = "R3 duty";
            chk($sformatf("%s vec %0d", tag, v), hi, int'(VECS[v].exp_hi));
        end

        // R6/R7: threshold moves from TOP to 10 just after a bottom
        div_sel = 3'd0; invert = 1'b0; cmp_in = 5'd31;
        @(negedge clk);
        pulse_clr(); wait_flag();
        pulse_clr(); wait_flag();
        pulse_clr(); wait_flag();
        cmp_in = 5'd10;
        begin
            int hi = 0;
            for (int k = 1; k <= 52; k++) begin
                @(negedge clk);
                if (k <= 30) hi += int'(pwm_out);
                if (k == 31) chk("R7 forced low at top", int'(pwm_out), 0);
                if (k == 51) chk("R3 low before falling match", int'(pwm_out), 0);
                if (k == 52) chk("R3 high at falling match", int'(pwm_out), 1);
            end
            chk("R6 old threshold kept on rising leg", hi, 30);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule